// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block keeps the status of one DMA channel that moves packet data between a memory buffer and a USB high-speed device endpoint. It holds four pieces of state:

- an enable state, which the control path and descriptor loads drive;
- an active flag, which follows the arbiter grant;
- three sticky event flags that clear when software reads the status word;
- a buffer byte down-counter.

The arbiter, the descriptor fetch engine, the FIFO datapath and the register bus appear only as single-cycle strobes and level inputs.

A transfer ends in one of two ways: the byte count runs out, or the device ends the transfer. Either way the enable state drops by itself. When the load-next bit of the last control write is set, the block then asks for the next descriptor. A software disable during a live packet does not take effect at once: the enable state holds until the FIFO reports empty. A buffer that runs out in the middle of a packet leaves the active flag set, so the packet can complete under the next descriptor.

Top module: `dma_chan_status`

## Requirements
- R1: `statusWord` layout:
  - bits 31:16 hold the byte count;
  - bit 0 is enable;
  - bit 1 is active;
  - bit 4 is end-of-transfer;
  - bit 5 is end-of-buffer;
  - bit 6 is descriptor-loaded;
  - every other bit reads 0.
- R2: The byte counter loads `ctrlCount` on a control write and `descCount` on a descriptor load. The descriptor wins if both happen in the same cycle. The counter drops by one per `byteStrobe` while enabled, and stays at 0 once it reaches 0.
- R3: When a `byteStrobe` takes the count from 1 to 0, the end-of-buffer flag sets and enable clears after that edge.
- R4: `xferEnd` while enabled sets the end-of-transfer flag and clears enable and active after that edge.
- R5: A cycle with `statusRd` high clears the three event flags at its edge. A set event for a flag in the same cycle leaves that flag set. With no read, a flag stays set.
- R6: A control write with `ctrlEnable`=0 while enabled, active and `fifoEmpty`=0 keeps enable at 1 until a cycle with `fifoEmpty`=1. That edge then clears enable and active. Without an active packet, or with `fifoEmpty`=1, the write clears enable at its own edge.
- R7: `grant` sets active only while enabled and not draining. `pktDone` clears active. `grant` while disabled has no effect.
- R8: An end-of-buffer leaves active set. Active stays set through a following descriptor load, until `pktDone`.
- R9: `descFetchReq` is high for exactly the one cycle after enable clears, and only if the last control write had `ctrlLoadNext`=1.
- R10: A descriptor load sets the descriptor-loaded flag, and sets enable if `descEnable`=1.
- R11: Synchronous active-high `rst` zeroes the count, all flags and `descFetchReq`, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrlWrEn | input | 1 | Software control write strobe |
| ctrlEnable | input | 1 | Enable bit of the control write |
| ctrlLoadNext | input | 1 | Load-next-descriptor bit of the control write |
| ctrlCount | input | CNT_W | Byte count of the control write |
| descLoad | input | 1 | Descriptor load strobe |
| descEnable | input | 1 | Enable bit of the loaded descriptor |
| descCount | input | CNT_W | Byte count of the loaded descriptor |
| grant | input | 1 | Arbiter grant: channel starts sourcing a packet |
| pktDone | input | 1 | Current packet transfer completed |
| xferEnd | input | 1 | Device ended the transfer |
| byteStrobe | input | 1 | One byte moved |
| fifoEmpty | input | 1 | Channel FIFO is empty |
| statusRd | input | 1 | Software read of the status word |
| statusWord | output | 32 | Status word |
| descFetchReq | output | 1 | Request to fetch the next descriptor |

## Verification
Two situations are hard to reach from the ports.

The first is the drain window. The stimulus grants the channel, holds `fifoEmpty` low, writes a disable, and then moves bytes during the window before it raises `fifoEmpty`.

The second is the active flag carried across a descriptor reload. The stimulus runs a buffer down to zero after a grant and without `pktDone`, loads a new enabled descriptor, and only then completes the packet.

Same-cycle collisions are driven on purpose:
- a read together with a descriptor load;
- a read together with the final byte;
- a control write together with a descriptor load.

// File: rtl/dma_chan_status_pkg.sv
package dma_chan_status_pkg;

  localparam int STATUS_W = 32;
  localparam int CNT_LSB  = 16;
  localparam int EN_BIT   = 0;
  localparam int ACT_BIT  = 1;
  localparam int TR_BIT   = 4;
  localparam int BF_BIT   = 5;
  localparam int DL_BIT   = 6;
  localparam int NUM_FLAGS = 3;

  // index of each sticky flag inside the flag bank
  localparam int FLAG_TR = 0;
  localparam int FLAG_BF = 1;
  localparam int FLAG_DL = 2;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DRAIN = 2'd2
  } chan_state_t;

  typedef struct packed {
    logic loadCtrl;
    logic loadDesc;
    logic decrement;
    logic setEndTr;
    logic setEndBf;
    logic setDescLd;
    logic readClr;
  } dp_strobes_t;

endpackage

// File: rtl/dma_chan_status_ctrl.sv
module dma_chan_status_ctrl
  import dma_chan_status_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrlWrEn,
  input  logic        ctrlEnable,
  input  logic        ctrlLoadNext,
  input  logic        descLoad,
  input  logic        descEnable,
  input  logic        grant,
  input  logic        pktDone,
  input  logic        xferEnd,
  input  logic        byteStrobe,
  input  logic        fifoEmpty,
  input  logic        statusRd,
  input  logic        cntIsZero,
  input  logic        cntIsOne,
  output dp_strobes_t strb,
  output logic        enSt,
  output logic        actSt,
  output logic        descFetchReq
);

  chan_state_t state, nextState;
  logic        ldNext;
  logic        nextAct;
  logic        bufEnd;
  logic        enClear;
  logic        actStop;
  logic        running;

  assign running = (state != CH_IDLE);

  // counter and flag strobes toward the datapath
  always_comb begin
    strb           = '0;
    strb.loadDesc  = descLoad;
    strb.loadCtrl  = ctrlWrEn & ~descLoad;
    strb.decrement = byteStrobe & running & ~cntIsZero & ~ctrlWrEn & ~descLoad;
    strb.setEndTr  = xferEnd & running;
    strb.setEndBf  = bufEnd;
    strb.setDescLd = descLoad;
    strb.readClr   = statusRd;
  end

  assign bufEnd = byteStrobe & running & cntIsOne & ~ctrlWrEn & ~descLoad;

  // channel enable state: descriptor load, then control write, then end events
  always_comb begin
    nextState = state;
    if (descLoad) begin
      nextState = descEnable ? CH_RUN : CH_IDLE;
    end else if (ctrlWrEn) begin
      if (ctrlEnable)
        nextState = CH_RUN;
      else if (running && actSt && !fifoEmpty)
        nextState = CH_DRAIN;
      else
        nextState = CH_IDLE;
    end else begin
      unique case (state)
        CH_RUN:   if (bufEnd || xferEnd) nextState = CH_IDLE;
        CH_DRAIN: if (fifoEmpty || xferEnd) nextState = CH_IDLE;
        default:  nextState = state;
      endcase
    end
  end

  assign enClear = running && (nextState == CH_IDLE);
  // a buffer end keeps the packet alive for the next descriptor
  assign actStop = enClear && !bufEnd;

  always_comb begin
    nextAct = actSt;
    if (grant && state == CH_RUN && !actStop)
      nextAct = 1'b1;
    else if (pktDone || actStop)
      nextAct = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= CH_IDLE;
      actSt        <= 1'b0;
      ldNext       <= 1'b0;
      descFetchReq <= 1'b0;
    end else begin
      state        <= nextState;
      actSt        <= nextAct;
      descFetchReq <= enClear && ldNext;
      if (ctrlWrEn)
        ldNext <= ctrlLoadNext;
    end
  end

  assign enSt = running;

endmodule

// File: rtl/dma_chan_status_dp.sv
module dma_chan_status_dp
  import dma_chan_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  dp_strobes_t         strb,
  input  logic [CNT_W-1:0]    ctrlCount,
  input  logic [CNT_W-1:0]    descCount,
  input  logic                enSt,
  input  logic                actSt,
  output logic                cntIsZero,
  output logic                cntIsOne,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int CNT_FIELD_W = STATUS_W - CNT_LSB;

  logic [CNT_W-1:0]     byteCnt;
  logic [NUM_FLAGS-1:0] flagSet;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [CNT_FIELD_W-1:0] cntField;

  always_ff @(posedge clk) begin
    if (rst)
      byteCnt <= '0;
    else if (strb.loadDesc)
      byteCnt <= descCount;
    else if (strb.loadCtrl)
      byteCnt <= ctrlCount;
    else if (strb.decrement)
      byteCnt <= byteCnt - CNT_W'(1);
  end

  assign cntIsZero = (byteCnt == '0);
  assign cntIsOne  = (byteCnt == CNT_W'(1));

  assign flagSet[FLAG_TR] = strb.setEndTr;
  assign flagSet[FLAG_BF] = strb.setEndBf;
  assign flagSet[FLAG_DL] = strb.setDescLd;

  // sticky flags: a set in the read cycle wins over the read clear
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flagQ[i] <= 1'b0;
      else if (flagSet[i])
        flagQ[i] <= 1'b1;
      else if (strb.readClr)
        flagQ[i] <= 1'b0;
    end
  end

  if (CNT_W < CNT_FIELD_W) begin : g_pad
    assign cntField = {{(CNT_FIELD_W - CNT_W){1'b0}}, byteCnt};
  end else begin : g_trunc
    assign cntField = byteCnt[CNT_FIELD_W-1:0];
  end

  always_comb begin
    statusWord                    = '0;
    statusWord[STATUS_W-1:CNT_LSB] = cntField;
    statusWord[EN_BIT]            = enSt;
    statusWord[ACT_BIT]           = actSt;
    statusWord[TR_BIT]            = flagQ[FLAG_TR];
    statusWord[BF_BIT]            = flagQ[FLAG_BF];
    statusWord[DL_BIT]            = flagQ[FLAG_DL];
  end

endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_chan_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrlWrEn,
  input  logic             ctrlEnable,
  input  logic             ctrlLoadNext,
  input  logic [CNT_W-1:0] ctrlCount,
  input  logic             descLoad,
  input  logic             descEnable,
  input  logic [CNT_W-1:0] descCount,
  input  logic             grant,
  input  logic             pktDone,
  input  logic             xferEnd,
  input  logic             byteStrobe,
  input  logic             fifoEmpty,
  input  logic             statusRd,
  output logic [31:0]      statusWord,
  output logic             descFetchReq
);

  dp_strobes_t strb;
  logic        enSt;
  logic        actSt;
  logic        cntIsZero;
  logic        cntIsOne;

  dma_chan_status_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .ctrlWrEn     (ctrlWrEn),
    .ctrlEnable   (ctrlEnable),
    .ctrlLoadNext (ctrlLoadNext),
    .descLoad     (descLoad),
    .descEnable   (descEnable),
    .grant        (grant),
    .pktDone      (pktDone),
    .xferEnd      (xferEnd),
    .byteStrobe   (byteStrobe),
    .fifoEmpty    (fifoEmpty),
    .statusRd     (statusRd),
    .cntIsZero    (cntIsZero),
    .cntIsOne     (cntIsOne),
    .strb         (strb),
    .enSt         (enSt),
    .actSt        (actSt),
    .descFetchReq (descFetchReq)
  );

  dma_chan_status_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .ctrlCount  (ctrlCount),
    .descCount  (descCount),
    .enSt       (enSt),
    .actSt      (actSt),
    .cntIsZero  (cntIsZero),
    .cntIsOne   (cntIsOne),
    .statusWord (statusWord)
  );

endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk (
  input logic        clk,
  input logic        rst,
  input logic        ctrlWrEn,
  input logic        ctrlEnable,
  input logic        descLoad,
  input logic        descEnable,
  input logic        grant,
  input logic        xferEnd,
  input logic        byteStrobe,
  input logic        fifoEmpty,
  input logic        statusRd,
  input logic [31:0] statusWord,
  input logic        descFetchReq
);

  // R1
  resv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    statusWord[15:7] == 9'd0 && statusWord[3:2] == 2'd0);

  // R2
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    statusWord[31:16] == 16'd0 && !ctrlWrEn && !descLoad |=> statusWord[31:16] == 16'd0);

  // R3
  buf_end_chk: assert property (@(posedge clk) disable iff (rst)
    statusWord[31:16] == 16'd1 && byteStrobe && statusWord[0] && !ctrlWrEn && !descLoad
    |=> statusWord[5] && !statusWord[0] && statusWord[31:16] == 16'd0);

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    statusRd && !byteStrobe && !xferEnd && !descLoad |=> statusWord[6:4] == 3'd0);

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    statusWord[5] && !statusRd |=> statusWord[5]);

  // R6
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    statusWord[0] && statusWord[1] && ctrlWrEn && !ctrlEnable && !fifoEmpty && !descLoad
    |=> statusWord[0]);

  // R7
  grant_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !statusWord[0] && !statusWord[1] |=> !statusWord[1]);

  // R9
  fetch_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    descFetchReq |-> !statusWord[0]);

  // R10
  desc_load_chk: assert property (@(posedge clk) disable iff (rst)
    descLoad && descEnable |=> statusWord[0] && statusWord[6]);

  // R4
  xfer_end_chk: assert property (@(posedge clk) disable iff (rst)
    xferEnd && statusWord[0] && !ctrlWrEn && !descLoad && !grant
    |=> statusWord[4] && !statusWord[0] && !statusWord[1]);

endmodule

bind dma_chan_status dma_chan_status_chk u_chk (.*);

// File: tb/dma_chan_status_bench.sv
`timescale 1ns/1ps
module dma_chan_status_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrlWrEn = 0, ctrlEnable = 0, ctrlLoadNext = 0;
  logic [15:0] ctrlCount = '0;
  logic        descLoad = 0, descEnable = 0;
  logic [15:0] descCount = '0;
  logic        grant = 0, pktDone = 0, xferEnd = 0, byteStrobe = 0;
  logic        fifoEmpty = 1, statusRd = 0;
  logic [31:0] statusWord;
  logic        descFetchReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] qWord[$];
  logic        qFetch[$];
  string       qTag[$];

  always #2 clk = ~clk;

  dma_chan_status u_dma_chan_status (
    .clk(clk), .rst(rst),
    .ctrlWrEn(ctrlWrEn), .ctrlEnable(ctrlEnable), .ctrlLoadNext(ctrlLoadNext),
    .ctrlCount(ctrlCount),
    .descLoad(descLoad), .descEnable(descEnable), .descCount(descCount),
    .grant(grant), .pktDone(pktDone), .xferEnd(xferEnd),
    .byteStrobe(byteStrobe), .fifoEmpty(fifoEmpty), .statusRd(statusRd),
    .statusWord(statusWord), .descFetchReq(descFetchReq)
  );

  function automatic logic [31:0] mk(input logic [15:0] cnt, input logic en,
      input logic act, input logic tr, input logic bf, input logic dl);
    mk = {cnt, 9'd0, dl, bf, tr, 2'b00, act, en};
  endfunction

  // edge, then release all strobes (levels fifoEmpty/rst stay)
  task automatic tick();
    @(posedge clk);
    #1;
    ctrlWrEn = 0; descLoad = 0; grant = 0; pktDone = 0;
    xferEnd = 0; byteStrobe = 0; statusRd = 0;
  endtask

  // driver side of the scoreboard
  task automatic expect_item(input logic [31:0] w, input logic f, input string tag);
    qWord.push_back(w);
    qFetch.push_back(f);
    qTag.push_back(tag);
  endtask

  task automatic ctrl_wr(input logic en, input logic ln, input logic [15:0] cnt);
    ctrlWrEn = 1; ctrlEnable = en; ctrlLoadNext = ln; ctrlCount = cnt;
  endtask

  task automatic desc_ld(input logic en, input logic [15:0] cnt);
    descLoad = 1; descEnable = en; descCount = cnt;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    while (qWord.size() > 0) begin
      logic [31:0] w;
      logic f;
      string t;
      w = qWord.pop_front();
      f = qFetch.pop_front();
      t = qTag.pop_front();
      checks++;
      if (statusWord !== w || descFetchReq !== f) begin
        errors++;
        $display("FAIL %s: word=%h fetch=%b expected word=%h fetch=%b",
                 t, statusWord, descFetchReq, w, f);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    // R11: reset dominates a control write
    ctrl_wr(1, 1, 16'd5); tick();
    expect_item(mk(0,0,0,0,0,0), 0, "R11 reset");
    tick(); rst = 0;

    // R1 R2: control write loads count and enable
    ctrl_wr(1, 1, 16'd3); tick();
    expect_item(mk(3,1,0,0,0,0), 0, "R1 R2 ctrl load");
    byteStrobe = 1; tick();
    expect_item(mk(2,1,0,0,0,0), 0, "R2 decrement");
    grant = 1; tick();
    expect_item(mk(2,1,1,0,0,0), 0, "R7 grant sets active");
    byteStrobe = 1; tick();
    expect_item(mk(1,1,1,0,0,0), 0, "R2 decrement to one");
    byteStrobe = 1; tick();
    expect_item(mk(0,0,1,0,1,0), 1, "R3 R8 R9 buffer end");
    tick();
    expect_item(mk(0,0,1,0,1,0), 0, "R9 fetch one cycle");
    byteStrobe = 1; tick();
    expect_item(mk(0,0,1,0,1,0), 0, "R2 saturate at zero");
    desc_ld(1, 16'd4); tick();
    expect_item(mk(4,1,1,0,1,1), 0, "R8 R10 active across descriptor");
    statusRd = 1; tick();
    expect_item(mk(4,1,1,0,0,0), 0, "R5 read clears");
    pktDone = 1; tick();
    expect_item(mk(4,1,0,0,0,0), 0, "R7 R8 pktDone clears active");
    grant = 1; tick();
    expect_item(mk(4,1,1,0,0,0), 0, "R7 grant again");
    byteStrobe = 1; tick();
    expect_item(mk(3,1,1,0,0,0), 0, "R2 decrement");
    xferEnd = 1; tick();
    expect_item(mk(3,0,0,1,0,0), 1, "R4 R9 device end");
    desc_ld(0, 16'd2); statusRd = 1; tick();
    expect_item(mk(2,0,0,0,0,1), 0, "R5 R10 set beats read");
    grant = 1; tick();
    expect_item(mk(2,0,0,0,0,1), 0, "R7 grant ignored when off");

    // R6: drain window
    ctrl_wr(1, 0, 16'd6); tick();
    expect_item(mk(6,1,0,0,0,1), 0, "R2 reload");
    grant = 1; byteStrobe = 1; tick();
    expect_item(mk(5,1,1,0,0,1), 0, "R7 R2 grant with byte");
    fifoEmpty = 0; ctrl_wr(0, 0, 16'd5); tick();
    expect_item(mk(5,1,1,0,0,1), 0, "R6 enable held while draining");
    tick();
    expect_item(mk(5,1,1,0,0,1), 0, "R6 still draining");
    grant = 1; byteStrobe = 1; tick();
    expect_item(mk(4,1,1,0,0,1), 0, "R6 bytes during drain");
    fifoEmpty = 1; tick();
    expect_item(mk(4,0,0,0,0,1), 0, "R6 R9 drain done no fetch");

    // R6: disable without active packet is immediate
    ctrl_wr(1, 0, 16'd2); tick();
    expect_item(mk(2,1,0,0,0,1), 0, "R2 reload");
    fifoEmpty = 0; ctrl_wr(0, 0, 16'd2); tick();
    expect_item(mk(2,0,0,0,0,1), 0, "R6 immediate disable");
    fifoEmpty = 1;

    // R5: buffer end in the read cycle keeps end-of-buffer
    ctrl_wr(1, 0, 16'd1); tick();
    expect_item(mk(1,1,0,0,0,1), 0, "R2 load one");
    byteStrobe = 1; statusRd = 1; tick();
    expect_item(mk(0,0,0,0,1,0), 0, "R3 R5 set beats read");

    // R2: descriptor load wins over control write
    ctrl_wr(1, 0, 16'd9); desc_ld(1, 16'd7); tick();
    expect_item(mk(7,1,0,0,1,1), 0, "R2 R10 descriptor priority");

    tick(); tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule